// File: doc/BRIEF.md
# Four-Channel Shared-Datapath FIR Filter

This block runs four independent FIR filters through a single iterative multiply-accumulate path. Once per sample period a strobe delivers one signed 16-bit sample for each channel. The samples land in per-channel circular buffers that all share one write pointer. A control machine then sweeps channel 0 through the last channel. For each channel it walks every tap, feeds a stored sample and its coefficient to a shift-add multiplier that retires one multiplier bit per clock, and adds the product into a wide accumulator.

At the end of each channel a 16-bit window of the accumulator is presented on the output. It appears together with a one-cycle valid pulse and the channel index. Coefficients live in internal register arrays, one bank per channel, and are written through a plain write port. At the default sizes (150 taps, 16-bit coefficients) a full sweep takes 4 × (150 × 16 + 1) = 9,604 clocks. That fits inside a 10,000-clock sample period. A strobe that arrives before the sweep has finished is dropped and latches an overrun flag.

Top module: `fir_mc_top`

## Requirements
- R1: After reset, the output is 0, valid and overrun are low, and every stored sample and coefficient is zero. A sweep before any coefficient write therefore yields 0 on every channel.
- R2: An accepted strobe writes bits [16c+15:16c] of the sample input into the circular buffer of channel c. Tap k of the following sweep uses the sample accepted k strobes earlier, and the buffer wraps modulo TAPS.
- R3: Each channel's result is the full-precision sum over k of coef[c][k] × x[n−k] in an ACC_W-bit two's-complement accumulator. The output carries accumulator bits SHIFT+15 down to SHIFT.
- R4: Each sweep raises the valid output for exactly one cycle per channel, in ascending channel order 0, 1, 2, 3. The channel index output names the channel during each pulse.
- R5: The valid pulse for channel c first appears (c+1) × (CW × TAPS + 1) clock edges after the edge that accepted the strobe. The multiplier takes CW cycles per tap, and a new product starts only when the multiplier is free.
- R6: A strobe sampled while a sweep is in progress sets the overrun output, which then stays high until reset. The samples presented with that strobe are discarded, and the running sweep's results are unchanged.
- R7: A strobe present in the same cycle as the last channel's valid pulse is accepted and starts a new sweep. A strobe one cycle earlier is an overrun.
- R8: A coefficient write stores the data at (channel, tap) and is used by every later sweep. A write whose tap index is TAPS or above has no effect.
- R9: Products are exact for all signed operand pairs, including −32768 × −32768 = +2^30 and −32768 × 32767.
- R10: The accumulator is zero when each channel's first product starts, so no value carries between channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | New-sample strobe, one cycle |
| samples_i | input | NCH×DW | One signed sample per channel, channel 0 in the low bits |
| cw_we_i | input | 1 | Coefficient write enable |
| cw_ch_i | input | log2(NCH) | Coefficient write channel |
| cw_tap_i | input | clog2(TAPS+1) | Coefficient write tap index |
| cw_data_i | input | CW | Signed coefficient value |
| y_o | output | DW | Filter result window |
| y_valid_o | output | 1 | One-cycle result strobe |
| y_ch_o | output | log2(NCH) | Channel of the current result |
| overrun_o | output | 1 | Sticky late-strobe flag |

## Verification
On every cycle, the bound checker confirms four things. Valid pulses last one cycle and follow the channel order. Each result lands at its exact cycle offset from the accepting strobe. Overrun rises on a late strobe and never falls, and the accumulator is clear at each channel start. Only the bench's scenarios can show that the numerical results are right. This covers extreme signed operands, buffer wrap-around, coefficient writes at out-of-range taps, and proof through later outputs that an overrun sample was really discarded.

// File: rtl/fir_mc_pkg.sv
package fir_mc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_WAIT  = 2'd2
    } fir_state_e;
endpackage

// File: rtl/fir_shadd_mul.sv
// Signed shift-add multiplier: magnitude product built one multiplier bit
// per cycle; done_o is raised in the last iteration with the final add
// folded in combinationally, so one product costs exactly BW cycles.
module fir_shadd_mul #(
    parameter int AW = 16,
    parameter int BW = 16,
    localparam int PW = AW + BW,
    localparam int CNTW = (BW > 1) ? $clog2(BW) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [AW-1:0] a_i,
    input  logic [BW-1:0] b_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [PW-1:0] prod_o
);
    localparam logic [CNTW-1:0] LAST = CNTW'(BW - 1);

    typedef struct packed {
        logic [PW-1:0]   mcand;
        logic [BW-1:0]   mplier;
        logic [PW-1:0]   acc;
        logic [CNTW-1:0] cnt;
        logic            busy;
        logic            neg;
    } mul_t;

    mul_t q, d;
    logic [AW-1:0] a_mag;
    logic [BW-1:0] b_mag;
    logic [PW-1:0] partial;

    always_comb begin
        a_mag   = a_i[AW-1] ? (~a_i + AW'(1)) : a_i;
        b_mag   = b_i[BW-1] ? (~b_i + BW'(1)) : b_i;
        partial = q.acc + (q.mplier[0] ? q.mcand : '0);
        done_o  = q.busy && (q.cnt == LAST);
        busy_o  = q.busy;
        prod_o  = q.neg ? (~partial + PW'(1)) : partial;

        d = q;
        if (q.busy) begin
            d.acc    = partial;
            d.mcand  = q.mcand << 1;
            d.mplier = q.mplier >> 1;
            d.cnt    = q.cnt + CNTW'(1);
            if (q.cnt == LAST) d.busy = 1'b0;
        end
        if (start_i) begin
            d.mcand  = {{BW{1'b0}}, a_mag};
            d.mplier = b_mag;
            d.acc    = '0;
            d.cnt    = '0;
            d.busy   = 1'b1;
            d.neg    = a_i[AW-1] ^ b_i[BW-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/fir_sbuf.sv
// Per-channel circular sample storage with one shared write pointer.
// A read addresses the sample accepted rd_tap_i strobes ago.
module fir_sbuf #(
    parameter int NCH  = 4,
    parameter int TAPS = 150,
    parameter int DW   = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int TW  = $clog2(TAPS + 1),
    localparam int IW  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [NCH*DW-1:0] wdata_i,
    input  logic [CHW-1:0]   rd_ch_i,
    input  logic [TW-1:0]    rd_tap_i,
    output logic [DW-1:0]    rd_data_o
);
    logic [IW-1:0] wp_d, wp_q;
    logic [IW-1:0] wp_nxt;
    logic [IW-1:0] rd_idx;
    logic [DW-1:0] rd_arr [NCH];

    always_comb begin
        int t, w, r;
        wp_nxt = (wp_q == IW'(TAPS - 1)) ? '0 : wp_q + IW'(1);
        wp_d   = wr_i ? wp_nxt : wp_q;
        t = int'(rd_tap_i);
        w = int'(wp_q);
        if (t >= TAPS)   r = 0;
        else if (t <= w) r = w - t;
        else             r = w + TAPS - t;
        rd_idx = IW'(r);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) wp_q <= '0;
        else         wp_q <= wp_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [DW-1:0] mem_q [TAPS];
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                for (int i = 0; i < TAPS; i++) mem_q[i] <= '0;
            end else if (wr_i) begin
                mem_q[wp_nxt] <= wdata_i[g*DW +: DW];
            end
        end
        assign rd_arr[g] = mem_q[rd_idx];
    end

    assign rd_data_o = rd_arr[rd_ch_i];
endmodule

// File: rtl/fir_cstore.sv
// Per-channel coefficient banks indexed by tap; writes at tap >= TAPS dropped.
module fir_cstore #(
    parameter int NCH  = 4,
    parameter int TAPS = 150,
    parameter int CW   = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int TW  = $clog2(TAPS + 1),
    localparam int IW  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_i,
    input  logic [CHW-1:0] wr_ch_i,
    input  logic [TW-1:0]  wr_tap_i,
    input  logic [CW-1:0]  wr_data_i,
    input  logic [CHW-1:0] rd_ch_i,
    input  logic [TW-1:0]  rd_tap_i,
    output logic [CW-1:0]  rd_data_o
);
    logic          wr_ok;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [CW-1:0] rd_arr [NCH];

    always_comb begin
        wr_ok  = wr_i && (wr_tap_i < TW'(TAPS));
        wr_idx = wr_tap_i[IW-1:0];
        rd_idx = (rd_tap_i < TW'(TAPS)) ? rd_tap_i[IW-1:0] : '0;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_bank
        logic [CW-1:0] mem_q [TAPS];
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                for (int i = 0; i < TAPS; i++) mem_q[i] <= '0;
            end else if (wr_ok && (wr_ch_i == CHW'(g))) begin
                mem_q[wr_idx] <= wr_data_i;
            end
        end
        assign rd_arr[g] = mem_q[rd_idx];
    end

    assign rd_data_o = rd_arr[rd_ch_i];
endmodule

// File: rtl/fir_mc_top.sv
module fir_mc_top
    import fir_mc_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int TAPS  = 150,
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int ACC_W = 40,
    parameter int SHIFT = 15,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int TW   = $clog2(TAPS + 1),
    localparam int PW   = DW + CW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              stb_i,
    input  logic [NCH*DW-1:0] samples_i,
    input  logic              cw_we_i,
    input  logic [CHW-1:0]    cw_ch_i,
    input  logic [TW-1:0]     cw_tap_i,
    input  logic [CW-1:0]     cw_data_i,
    output logic [DW-1:0]     y_o,
    output logic              y_valid_o,
    output logic [CHW-1:0]    y_ch_o,
    output logic              overrun_o
);
    typedef struct packed {
        fir_state_e       state;
        logic [CHW-1:0]   ch;
        logic [TW-1:0]    tap;
        logic [ACC_W-1:0] acc;
        logic [DW-1:0]    y;
        logic             yv;
        logic [CHW-1:0]   ych;
        logic             ovr;
    } ctl_t;

    ctl_t q, d;

    logic             accept;
    logic             mul_start, mul_busy, mul_done;
    logic [PW-1:0]    prod;
    logic [ACC_W-1:0] acc_sum;
    logic [TW-1:0]    rd_tap;
    logic [DW-1:0]    smp;
    logic [CW-1:0]    coef;
    logic             idle_w, start_st_w;

    assign accept     = stb_i && (q.state == ST_IDLE);
    assign idle_w     = (q.state == ST_IDLE);
    assign start_st_w = (q.state == ST_START);

    fir_sbuf #(.NCH(NCH), .TAPS(TAPS), .DW(DW)) i_sbuf (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (accept),
        .wdata_i  (samples_i),
        .rd_ch_i  (q.ch),
        .rd_tap_i (rd_tap),
        .rd_data_o(smp)
    );

    fir_cstore #(.NCH(NCH), .TAPS(TAPS), .CW(CW)) i_cstore (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (cw_we_i),
        .wr_ch_i  (cw_ch_i),
        .wr_tap_i (cw_tap_i),
        .wr_data_i(cw_data_i),
        .rd_ch_i  (q.ch),
        .rd_tap_i (rd_tap),
        .rd_data_o(coef)
    );

    fir_shadd_mul #(.AW(DW), .BW(CW)) i_mul (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(mul_start),
        .a_i    (smp),
        .b_i    (coef),
        .busy_o (mul_busy),
        .done_o (mul_done),
        .prod_o (prod)
    );

    always_comb begin
        d         = q;
        d.yv      = 1'b0;
        mul_start = 1'b0;
        rd_tap    = q.tap;
        acc_sum   = q.acc + {{(ACC_W-PW){prod[PW-1]}}, prod};

        if (stb_i && (q.state != ST_IDLE)) d.ovr = 1'b1;

        unique case (q.state)
            ST_IDLE: begin
                if (stb_i) begin
                    d.state = ST_START;
                    d.ch    = '0;
                    d.tap   = '0;
                    d.acc   = '0;
                end
            end
            ST_START: begin
                mul_start = 1'b1;
                d.state   = ST_WAIT;
            end
            ST_WAIT: begin
                rd_tap = q.tap + TW'(1);
                if (mul_done) begin
                    d.acc = acc_sum;
                    if (q.tap == TW'(TAPS - 1)) begin
                        d.y   = acc_sum[SHIFT+DW-1 -: DW];
                        d.yv  = 1'b1;
                        d.ych = q.ch;
                        d.acc = '0;
                        d.tap = '0;
                        if (q.ch == CHW'(NCH - 1)) begin
                            d.state = ST_IDLE;
                        end else begin
                            d.ch    = q.ch + CHW'(1);
                            d.state = ST_START;
                        end
                    end else begin
                        d.tap     = q.tap + TW'(1);
                        mul_start = 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign y_o       = q.y;
    assign y_valid_o = q.yv;
    assign y_ch_o    = q.ych;
    assign overrun_o = q.ovr;
endmodule

// File: rtl/fir_mc_chk.sv
module fir_mc_chk #(
    parameter int NCH   = 4,
    parameter int TAPS  = 150,
    parameter int CW    = 16,
    parameter int ACC_W = 40,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int PER  = CW * TAPS + 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             stb_i,
    input logic             idle_i,
    input logic             start_st_i,
    input logic [ACC_W-1:0] acc_i,
    input logic             mul_start_i,
    input logic             mul_busy_i,
    input logic             mul_done_i,
    input logic             y_valid_i,
    input logic [CHW-1:0]   y_ch_i,
    input logic             overrun_i
);
    logic [CHW-1:0] exp_ch_q;
    logic [31:0]    cyc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            exp_ch_q <= '0;
            cyc_q    <= '0;
        end else begin
            if (stb_i && idle_i)  exp_ch_q <= '0;
            else if (y_valid_i)   exp_ch_q <= exp_ch_q + CHW'(1);
            if (stb_i && idle_i)  cyc_q <= '0;
            else if (cyc_q != 32'hFFFF_FFFF) cyc_q <= cyc_q + 32'd1;
        end
    end

    p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        y_valid_i |=> !y_valid_i);

    p_ch_seq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        y_valid_i |-> (y_ch_i == exp_ch_q));

    p_timing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        y_valid_i |-> (cyc_q == (32'(y_ch_i) + 32'd1) * 32'(PER)));

    p_mul_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mul_start_i |-> (!mul_busy_i || mul_done_i));

    p_ovr_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb_i && !idle_i) |=> overrun_i);

    p_ovr_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_i |=> overrun_i);

    p_acc_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_st_i |-> (acc_i == '0));
endmodule

bind fir_mc_top fir_mc_chk #(
    .NCH(NCH), .TAPS(TAPS), .CW(CW), .ACC_W(ACC_W)
) i_fir_mc_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (stb_i),
    .idle_i     (idle_w),
    .start_st_i (start_st_w),
    .acc_i      (q.acc),
    .mul_start_i(mul_start),
    .mul_busy_i (mul_busy),
    .mul_done_i (mul_done),
    .y_valid_i  (y_valid_o),
    .y_ch_i     (y_ch_o),
    .overrun_i  (overrun_o)
);

// File: tb/test_fir_mc_top.sv
module test_fir_mc_top;
    localparam int NCH  = 4;
    localparam int TAPS = 5;
    localparam int SH   = 8;
    localparam int PER  = 16 * TAPS + 1;
    localparam int TW   = $clog2(TAPS + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stb = 1'b0;
    logic [63:0] samples = '0;
    logic        cw_we = 1'b0;
    logic [1:0]  cw_ch = '0;
    logic [TW-1:0] cw_tap = '0;
    logic [15:0] cw_data = '0;
    logic [15:0] y;
    logic        yv;
    logic [1:0]  ych;
    logic        ovr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    longint coef_m [NCH][TAPS];
    longint hist_m [NCH][TAPS];

    always #2 clk = ~clk;

    fir_mc_top #(.NCH(NCH), .TAPS(TAPS), .SHIFT(SH)) i_fir_mc_top (
        .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .samples_i(samples),
        .cw_we_i(cw_we), .cw_ch_i(cw_ch), .cw_tap_i(cw_tap), .cw_data_i(cw_data),
        .y_o(y), .y_valid_o(yv), .y_ch_o(ych), .overrun_o(ovr)
    );

    localparam logic [63:0] VEC [8] = '{
        64'h0004_0003_0002_0001,
        64'h8000_8000_8000_8000,
        64'h7FFF_7FFF_7FFF_7FFF,
        64'h8000_1234_0000_FFFF,
        64'h7FFF_00FF_FF00_0100,
        64'h0000_8001_7FFF_8000,
        64'hF0F0_0F0F_A5A5_5A5A,
        64'h0000_0000_0000_0000
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_y(input int c);
        longint s = 0;
        for (int k = 0; k < TAPS; k++) s += coef_m[c][k] * hist_m[c][k];
        return 16'(s >>> SH);
    endfunction

    task automatic push_model(input logic [63:0] s);
        for (int c = 0; c < NCH; c++) begin
            for (int k = TAPS - 1; k > 0; k--) hist_m[c][k] = hist_m[c][k-1];
            hist_m[c][0] = longint'($signed(s[c*16 +: 16]));
        end
    endtask

    task automatic load_coef(input int c, input int t, input logic [15:0] v);
        cw_we = 1'b1; cw_ch = 2'(c); cw_tap = TW'(t); cw_data = v;
        @(posedge clk); #1;
        cw_we = 1'b0;
        if (t < TAPS) coef_m[c][t] = longint'($signed(v));
    endtask

    // Strobe s now (one cycle after a posedge), optionally raise a late strobe
    // after edge late_n; run until the last channel's valid is visible.
    task automatic sweep(input logic [63:0] s, input int late_n, input logic [63:0] late_s,
                         input string tag);
        int got = 0;
        logic [15:0] ex [NCH];
        stb = 1'b1; samples = s;
        @(posedge clk); #1;
        stb = 1'b0;
        push_model(s);
        for (int c = 0; c < NCH; c++) ex[c] = model_y(c);
        for (int n = 1; n <= NCH * PER; n++) begin
            @(posedge clk); #1;
            stb = 1'b0;
            if (yv) begin
                chk(ych == 2'(got), {tag, " R4 channel order"}, longint'(ych), longint'(got));
                chk(n == (got + 1) * PER, {tag, " R5 result edge"}, longint'(n), longint'((got + 1) * PER));
                if (got < NCH)
                    chk(y == ex[got], {tag, " R3 result value"}, longint'(y), longint'(ex[got]));
                got++;
            end
            if (n == late_n) begin
                stb = 1'b1; samples = late_s;
            end
        end
        chk(got == NCH, {tag, " R4 pulse count"}, longint'(got), longint'(NCH));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < TAPS; k++) begin coef_m[c][k] = 0; hist_m[c][k] = 0; end

        repeat (3) @(posedge clk); #1;
        chk(y == 16'h0, "R1 reset y", longint'(y), 0);
        chk(yv == 1'b0, "R1 reset valid", longint'(yv), 0);
        chk(ovr == 1'b0, "R1 reset overrun", longint'(ovr), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: coefficients cleared, results zero despite nonzero samples
        sweep(64'h1111_2222_3333_4444, 0, '0, "R1 zero coefs");
        for (int c = 0; c < NCH; c++)
            chk(model_y(c) == 16'h0, "R1 model zero", longint'(model_y(c)), 0);

        // Coefficient banks (R8, R9 extremes)
        for (int k = 0; k < TAPS; k++) load_coef(0, k, 16'(k + 1));
        load_coef(1, 0, 16'h8000); load_coef(1, 1, 16'h7FFF); load_coef(1, 2, 16'hFFFF);
        load_coef(1, 3, 16'd100);  load_coef(1, 4, 16'hFF38);
        load_coef(2, 0, 16'h0100); load_coef(2, 1, 16'hFF00); load_coef(2, 4, 16'h0007);
        for (int k = 0; k < TAPS; k++) load_coef(3, k, 16'h7FFF);
        // R8: writes to taps at or beyond TAPS must not disturb any bank
        for (int t = TAPS; t < (1 << TW); t++) load_coef(0, t, 16'h5555);

        // Vector table: several patterns, wraps the circular buffer (R2, R3, R9)
        for (int v = 0; v < 8; v++) sweep(VEC[v], 0, '0, "R2 vector");

        // R9: newest sample -32768 times coefficient -32768 on channel 1
        sweep(64'h0000_0000_8000_0000, 0, '0, "R9 extreme");
        chk(ovr == 1'b0, "R6 no overrun yet", longint'(ovr), 0);

        // R6: early late strobe is dropped, current sweep unaffected
        sweep(64'h0101_0202_0303_0404, 10, 64'h7777_7777_7777_7777, "R6 mid overrun");
        chk(ovr == 1'b1, "R6 overrun set", longint'(ovr), 1);
        // R7: one cycle before the last valid is still an overrun
        sweep(64'h0A0A_0B0B_0C0C_0D0D, NCH * PER - 1, 64'h6666_6666_6666_6666, "R7 late overrun");
        // R6/R7: next sweep shows neither dropped sample entered the buffer;
        // it is issued in the same cycle as the last valid (R7 acceptance).
        sweep(64'h0001_0001_0001_0001, 0, '0, "R7 back-to-back");
        chk(ovr == 1'b1, "R6 overrun sticky", longint'(ovr), 1);

        // R8: rewritten coefficient used by later sweeps
        load_coef(0, 0, 16'hC000);
        load_coef(2, 2, 16'h1234);
        sweep(64'h0200_0300_0400_0500, 0, '0, "R8 rewrite");
        sweep(64'h8000_8000_8000_8000, 0, '0, "R10 no carry");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule